// File: doc/BRIEF.md
# Two-Line Maskable Interrupt Router

This block collects a vector of level-sensitive interrupt requests, each already enabled inside the peripheral that drives it. A per-bit gate register decides which requests may reach the processor. A per-bit route register steers each admitted request to either the fast interrupt line or the normal interrupt line. Each source input stands for the OR of several conditions inside its device, so the router treats it as a plain level and keeps no history of it.

Software sees four word registers on a simple bus with single-cycle write strobes and combinational read data. The gate and route registers can be read and written. The two pending views are read-only and show the admitted requests for each line as they are in the current cycle. The gate and route registers hold no defined value for software until they are programmed. For a deterministic simulation they are cleared by the synchronous reset.

While the idle input is high, any active source raises a wake request and the gate register plays no part. Both processor lines and the wake request are registered, so they follow the inputs one clock later.

Top module: `dual_route_intc`

## Requirements
- R1: A write strobe at byte offset 0x4 loads the gate register (bit = 1 admits the source, 0 blocks it). A write at offset 0x8 loads the route register (bit = 1 selects the fast line, 0 the normal line). Reads at these offsets return the stored values.
- R2: A read at offset 0x0 returns, in the same cycle, the normal-line pending view: src AND gate AND NOT route.
- R3: A read at offset 0xC returns, in the same cycle, the fast-line pending view: src AND gate AND route.
- R4: `irq_o` equals, one clock later, the OR of all bits of the normal-line pending view.
- R5: `fiq_o` equals, one clock later, the OR of all bits of the fast-line pending view.
- R6: While `idle_i` is high, any active source bit sets `wake_o` one clock later, whatever the gate register holds.
- R7: Writes to offsets 0x0 and 0xC change no register. The gate and route registers keep their values.
- R8: The pending views are not latched. A pending bit reads 0 in the same cycle its source drops.
- R9: While `rst` is high, `irq_o`, `fiq_o` and `wake_o` are low at every clock, whatever the inputs are.
- R10: While `idle_i` is low, `wake_o` is low one clock later, even when sources are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC (32) | Level-sensitive interrupt sources |
| idle_i | input | 1 | Idle-mode indication; enables wake on any source |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| addr_i | input | AW (4) | Register byte address |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Combinational read data |
| irq_o | output | 1 | Normal processor interrupt, registered |
| fiq_o | output | 1 | Fast processor interrupt, registered |
| wake_o | output | 1 | Wake request, registered |

## Verification
The two pending views are due in the same cycle as the stimulus. The bench therefore changes sources or the address at the falling edge and reads `rdata_o` a time step later, before any rising edge. `irq_o`, `fiq_o` and `wake_o` are due after exactly one rising edge. They are sampled at the next falling edge, with no input change in between. A register write takes effect at the rising edge that samples its strobe, so readbacks happen at the falling edge after that.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Byte offsets of the four word registers
  localparam logic [3:0] OFS_IRQ_PEND = 4'h0;
  localparam logic [3:0] OFS_GATE     = 4'h4;
  localparam logic [3:0] OFS_ROUTE    = 4'h8;
  localparam logic [3:0] OFS_FIQ_PEND = 4'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IRQ_PEND,
    SEL_GATE,
    SEL_ROUTE,
    SEL_FIQ_PEND
  } reg_sel_e;
endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] pend_irq,
  input  logic [NSRC-1:0] pend_fiq,
  output logic [NSRC-1:0] gate_q,
  output logic [NSRC-1:0] route_q,
  output logic [DW-1:0]   rdata
);
  reg_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (addr == AW'(OFS_IRQ_PEND))      sel = SEL_IRQ_PEND;
    else if (addr == AW'(OFS_GATE))     sel = SEL_GATE;
    else if (addr == AW'(OFS_ROUTE))    sel = SEL_ROUTE;
    else if (addr == AW'(OFS_FIQ_PEND)) sel = SEL_FIQ_PEND;
  end

  // Only the gate and route registers take writes; pending views are read-only
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_GATE)  gate_q  <= wdata[NSRC-1:0];
      if (sel == SEL_ROUTE) route_q <= wdata[NSRC-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_IRQ_PEND: rdata = DW'(pend_irq);
      SEL_GATE:     rdata = DW'(gate_q);
      SEL_ROUTE:    rdata = DW'(route_q);
      SEL_FIQ_PEND: rdata = DW'(pend_fiq);
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_qualify.sv
module intc_qualify #(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] gate,
  input  logic [NSRC-1:0] route,
  input  logic            idle,
  output logic [NSRC-1:0] pend_irq,
  output logic [NSRC-1:0] pend_fiq,
  output logic            wake_req
);
  // Per-source admission and steering
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic admit;
    assign admit       = src[i] & gate[i];
    assign pend_fiq[i] = admit & route[i];
    assign pend_irq[i] = admit & ~route[i];
  end

  // Idle wake ignores the gate entirely
  assign wake_req = idle & (|src);
endmodule

// File: rtl/intc_linereg.sv
module intc_linereg #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend_irq,
  input  logic [NSRC-1:0] pend_fiq,
  input  logic            wake_req,
  output logic            irq_q,
  output logic            fiq_q,
  output logic            wake_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      fiq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= |pend_irq;
      fiq_q  <= |pend_fiq;
      wake_q <= wake_req;
    end
  end
endmodule

// File: rtl/dual_route_intc.sv
module dual_route_intc #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            idle_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            wake_o
);
  logic [NSRC-1:0] gate_q;
  logic [NSRC-1:0] route_q;
  logic [NSRC-1:0] pend_irq;
  logic [NSRC-1:0] pend_fiq;
  logic            wake_req;

  intc_regfile #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en_i),
    .addr     (addr_i),
    .wdata    (wdata_i),
    .pend_irq (pend_irq),
    .pend_fiq (pend_fiq),
    .gate_q   (gate_q),
    .route_q  (route_q),
    .rdata    (rdata_o)
  );

  intc_qualify #(.NSRC(NSRC)) u_qual (
    .src      (src_i),
    .gate     (gate_q),
    .route    (route_q),
    .idle     (idle_i),
    .pend_irq (pend_irq),
    .pend_fiq (pend_fiq),
    .wake_req (wake_req)
  );

  intc_linereg #(.NSRC(NSRC)) u_lines (
    .clk      (clk),
    .rst      (rst),
    .pend_irq (pend_irq),
    .pend_fiq (pend_fiq),
    .wake_req (wake_req),
    .irq_q    (irq_o),
    .fiq_q    (fiq_o),
    .wake_q   (wake_o)
  );
endmodule

// File: rtl/dual_route_intc_checker.sv
module dual_route_intc_checker #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_i,
  input logic            idle_i,
  input logic            wr_en_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   rdata_o,
  input logic            irq_o,
  input logic            fiq_o,
  input logic            wake_o,
  input logic [NSRC-1:0] gate_q,
  input logic [NSRC-1:0] route_q
);
  a_r1_gate_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == AW'(4'h4)) |=> gate_q == $past(wdata_i[NSRC-1:0]));

  a_r2_irq_view: assert property (@(posedge clk) disable iff (rst)
    (addr_i == AW'(4'h0)) |-> rdata_o == DW'(src_i & gate_q & ~route_q));

  a_r3_fiq_view: assert property (@(posedge clk) disable iff (rst)
    (addr_i == AW'(4'hC)) |-> rdata_o == DW'(src_i & gate_q & route_q));

  a_r4_irq_line: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == $past(|(src_i & gate_q & ~route_q)));

  a_r5_fiq_line: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fiq_o == $past(|(src_i & gate_q & route_q)));

  a_r6_idle_wake: assert property (@(posedge clk) disable iff (rst)
    (idle_i && |src_i) |=> wake_o);

  a_r7_pend_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (addr_i == AW'(4'h0) || addr_i == AW'(4'hC)))
      |=> ($stable(gate_q) && $stable(route_q)));

  a_r10_no_wake_awake: assert property (@(posedge clk) disable iff (rst)
    !idle_i |=> !wake_o);
endmodule

bind dual_route_intc dual_route_intc_checker #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_i   (src_i),
  .idle_i  (idle_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .wake_o  (wake_o),
  .gate_q  (gate_q),
  .route_q (route_q)
);

// File: tb/dual_route_intc_test.sv
module dual_route_intc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [31:0] gate;
    logic [31:0] route;
    logic [31:0] src;
    logic        idle;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 1'b0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0},
    '{32'h0000_FFFF, 32'h00FF_00FF, 32'h1234_5678, 1'b0},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
    '{32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF, 1'b0},
    '{32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0F0F_0F0F, 1'b1},
    '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0001_0000, 1'b0},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic        idle_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o, wake_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_route_intc uut (
    .clk (clk), .rst (rst), .src_i (src_i), .idle_i (idle_i),
    .wr_en_i (wr_en_i), .addr_i (addr_i), .wdata_i (wdata_i),
    .rdata_o (rdata_o), .irq_o (irq_o), .fiq_o (fiq_o), .wake_o (wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic read_at(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    // R9: outputs held low in reset even with idle wake conditions present
    src_i = 32'hFFFF_FFFF; idle_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 irq_o in reset", {31'b0, irq_o}, 32'd0);
    check("R9 fiq_o in reset", {31'b0, fiq_o}, 32'd0);
    check("R9 wake_o in reset", {31'b0, wake_o}, 32'd0);
    src_i = '0; idle_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // Table walk: R1 to R6 and R10
    for (int v = 0; v < NV; v++) begin
      logic [31:0] exp_irq, exp_fiq;
      bus_write(4'h4, VECS[v].gate);
      bus_write(4'h8, VECS[v].route);
      read_at(4'h4, rd); check("R1 gate readback", rd, VECS[v].gate);
      read_at(4'h8, rd); check("R1 route readback", rd, VECS[v].route);
      exp_irq = VECS[v].src & VECS[v].gate & ~VECS[v].route;
      exp_fiq = VECS[v].src & VECS[v].gate & VECS[v].route;
      src_i = VECS[v].src; idle_i = VECS[v].idle;
      read_at(4'h0, rd); check("R2 irq pending view", rd, exp_irq);
      read_at(4'hC, rd); check("R3 fiq pending view", rd, exp_fiq);
      @(posedge clk);
      @(negedge clk);
      check("R4 irq_o line", {31'b0, irq_o}, {31'b0, |exp_irq});
      check("R5 fiq_o line", {31'b0, fiq_o}, {31'b0, |exp_fiq});
      if (VECS[v].idle)
        check("R6 wake_o in idle", {31'b0, wake_o}, {31'b0, |VECS[v].src});
      else
        check("R10 wake_o awake", {31'b0, wake_o}, 32'd0);
    end

    // R7: writes to pending offsets change nothing
    src_i = '0; idle_i = 1'b0;
    bus_write(4'h4, 32'h0000_1234);
    bus_write(4'h8, 32'h0000_00FF);
    bus_write(4'h0, 32'hDEAD_BEEF);
    bus_write(4'hC, 32'hCAFE_F00D);
    read_at(4'h4, rd); check("R7 gate unchanged", rd, 32'h0000_1234);
    read_at(4'h8, rd); check("R7 route unchanged", rd, 32'h0000_00FF);
    read_at(4'h0, rd); check("R7 irq view still zero", rd, 32'd0);
    read_at(4'hC, rd); check("R7 fiq view still zero", rd, 32'd0);

    // R8: pending view follows the live source
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'h0000_0000);
    src_i = 32'h0000_0020;
    read_at(4'h0, rd); check("R8 pending set", rd, 32'h0000_0020);
    @(posedge clk);
    @(negedge clk);
    check("R8 irq_o raised", {31'b0, irq_o}, 32'd1);
    src_i = '0;
    read_at(4'h0, rd); check("R8 pending clears same cycle", rd, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8 irq_o drops", {31'b0, irq_o}, 32'd0);

    // R6: idle wake with every source blocked; R10: wake drops when idle ends
    bus_write(4'h4, 32'h0000_0000);
    src_i = 32'h0400_0000; idle_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6 wake despite gate", {31'b0, wake_o}, 32'd1);
    check("R4 irq_o blocked", {31'b0, irq_o}, 32'd0);
    idle_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 wake cleared", {31'b0, wake_o}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule